// File: doc/BRIEF.md
# Supply-Pulse Programming Key Decoder

This block sits behind the analog level detector of a programmable magnetic switch. The level detector reports each finished programming pulse on the supply line as one event. The event says whether the pulse reached the mid level or the high level, and it carries the pulse duration in clock ticks. A separate strobe reports that the supply was cycled. The decoder matches serial sequences of mid and high pulses against a small set of keys. From them it selects one of five temporary trial registers or one of three fuse-access registers. It then tracks the trial code or the one-hot fuse address that later mid pulses step through.

Several keys share a prefix, so the register choice is settled only when the final high pulse arrives. A run of mid pulses after a complete up-counting or output key first acts as ordinary code steps. If a high pulse then follows, the length of that run decides between the down-counting variant, the fuse-access mode and an error. An error holds until the next supply cycle. In fuse-access mode the decoder starts as a read port. A long high pulse turns it into a one-cycle blow strobe, and after that it waits for a supply cycle.

Top module: `hk_key_decoder`

## Requirements
- R1: Keys select trial registers with mode=1 and code=1, encoded as sel: H H gives sel 1, H M H H gives sel 2, H M M M H gives sel 5. H is a high pulse (pulse_kind=1) and M is a mid pulse (pulse_kind=0).
- R2: After sel 1 or sel 2 has been entered, exactly four M followed by H switches to the down-counting variant (sel 3 or sel 4 respectively) and sets code back to 1.
- R3: Eleven M followed by H selects mode=2 with fuse_addr=1. This works after sel 1 (giving sel 6), after sel 5 (giving sel 8) and after the prefix H M H (giving sel 7). Each M shifts fuse_addr left by one. An M when the address already sits on the register's top bit raises err. The register widths are 8, 1 and 5 bits for sel 6, 7 and 8.
- R4: In mode 1 each M increments code. In sel 1 to sel 4 the code wraps from 255 to 0. In sel 5 it saturates at 255.
- R5: In sel 1 and sel 2, mag_sel equals code. In sel 3 and sel 4, mag_sel equals 255 minus code. trim_neg is 1 exactly for sel 2 and sel 4.
- R6: In sel 5, fall_sel equals code bits 1:0 and pol_sel equals code bit 2. chk_lo is 1 only at code 8 and chk_hi is 1 only at code 9.
- R7: With lock_fuse=1, any key that would reach sel 1, sel 2 or a fuse-access register raises err. Sel 5 stays reachable, but fall_sel and pol_sel are held at 0 while chk_lo and chk_hi keep working.
- R8: A pulse whose pulse_len is below ACT_MIN (4) has no effect on any output.
- R9: In mode 2, an H with pulse_len of at least BLOW_MIN (20) gives blow_stb=1 for exactly one cycle and sets mode=3 with fuse_addr held. Later pulses are then ignored. A long H in any other state raises err.
- R10: A sequence that matches no key raises err with sel=0 and mode=0. err stays set until pwr_cycle.
- R11: pwr_cycle returns all outputs to their reset values. It wins over a pulse event presented in the same cycle.
- R12: After reset, sel, mode, code, fuse_addr, err and blow_stb are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_cycle | input | 1 | Supply-cycle strobe, clears all session state |
| lock_fuse | input | 1 | Lock fuse state from fuse storage |
| pulse_valid | input | 1 | One-cycle pulse event |
| pulse_kind | input | 1 | 0 = mid level, 1 = high level |
| pulse_len | input | LEN_W | Pulse duration in ticks |
| sel | output | 4 | Selected register |
| mode | output | 2 | 0 idle/keying, 1 trial, 2 read, 3 blown |
| err | output | 1 | Sticky key error |
| blow_stb | output | 1 | One-cycle fuse blow request |
| code | output | CODE_W | Trial code |
| mag_sel | output | CODE_W | Applied threshold magnitude select |
| trim_neg | output | 1 | Negative-field trim register selected |
| fall_sel | output | 2 | Trial fall-time field |
| pol_sel | output | 1 | Trial output polarity field |
| chk_lo | output | 1 | Intact-fuse check active |
| chk_hi | output | 1 | Blown-fuse check active |
| fuse_addr | output | ADDR_W | One-hot fuse address |

## Verification
Two things can land on the same clock edge: a supply-cycle strobe and a pulse event. The bench provokes this by raising pwr_cycle and a valid high pulse together. It judges the outcome from what follows. Two further high pulses must then land on sel 1 with no error, which can only happen if the simultaneous pulse was discarded. A second case is the M that ends a code walk through 255. Here the wrap and the step happen in one cycle, and the bench confirms that the next code is 0.

// File: rtl/hk_pkg.sv
package hk_pkg;
  typedef enum logic [3:0] {
    SEL_NONE    = 4'd0,
    SEL_TRIM_PU = 4'd1,
    SEL_TRIM_NU = 4'd2,
    SEL_TRIM_PD = 4'd3,
    SEL_TRIM_ND = 4'd4,
    SEL_OUTCHK  = 4'd5,
    SEL_F_MAG   = 4'd6,
    SEL_F_SIGN  = 4'd7,
    SEL_F_OLCK  = 4'd8
  } sel_e;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_TRY  = 2'd1,
    MODE_READ = 2'd2,
    MODE_BLOW = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    K_IDLE, K_H, K_HM, K_HMH, K_HMHM, K_TRY, K_FUSE, K_BLOWN, K_ERR
  } kst_e;
endpackage

// File: rtl/hk_pulse_class.sv
module hk_pulse_class #(
  parameter int LEN_W    = 8,
  parameter int ACT_MIN  = 4,
  parameter int BLOW_MIN = 20
) (
  input  logic             valid,
  input  logic             kind,
  input  logic [LEN_W-1:0] len,
  output logic             ev_mid,
  output logic             ev_key,
  output logic             ev_blow
);
  localparam logic [LEN_W-1:0] ACT_L  = LEN_W'(ACT_MIN);
  localparam logic [LEN_W-1:0] BLOW_L = LEN_W'(BLOW_MIN);

  logic long_ok;
  logic blow_len;

  always_comb begin
    long_ok  = (len >= ACT_L);
    blow_len = (len >= BLOW_L);
    ev_mid   = valid & ~kind & long_ok;
    ev_key   = valid &  kind & long_ok & ~blow_len;
    ev_blow  = valid &  kind & blow_len;
  end
endmodule

// File: rtl/hk_key_fsm.sv
module hk_key_fsm
  import hk_pkg::*;
#(
  parameter int RUN_DOWN = 4,
  parameter int RUN_MODE = 11,
  parameter int RUN_OUT  = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pwr_cycle,
  input  logic  ev_mid,
  input  logic  ev_key,
  input  logic  ev_blow,
  input  logic  locked,
  input  logic  addr_top,
  output sel_e  sel_q,
  output mode_e mode,
  output logic  err,
  output logic  blow_stb,
  output logic  try_load,
  output logic  try_inc,
  output logic  wrap_en,
  output logic  code_clr,
  output logic  fuse_load,
  output logic  fuse_shift,
  output logic  fuse_clr
);
  localparam int RUN_MAX = RUN_MODE + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] C_DOWN = RUN_W'(RUN_DOWN);
  localparam logic [RUN_W-1:0] C_MODE = RUN_W'(RUN_MODE);
  localparam logic [RUN_W-1:0] C_OUT  = RUN_W'(RUN_OUT);
  localparam logic [RUN_W-1:0] C_ONE  = RUN_W'(1);
  localparam logic [RUN_W-1:0] C_MAX  = RUN_W'(RUN_MAX);

  kst_e             st_q, st_d;
  sel_e             sel_d;
  logic [RUN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             stb_q, stb_d;
  logic             go_err;

  always_comb begin
    st_d       = st_q;
    sel_d      = sel_q;
    cnt_d      = cnt_q;
    stb_d      = 1'b0;
    try_load   = 1'b0;
    try_inc    = 1'b0;
    fuse_load  = 1'b0;
    fuse_shift = 1'b0;
    go_err     = 1'b0;
    cnt_inc    = (cnt_q == C_MAX) ? cnt_q : cnt_q + C_ONE;

    if (pwr_cycle) begin
      st_d  = K_IDLE;
      sel_d = SEL_NONE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        K_IDLE: begin
          if (ev_key) st_d = K_H;
          else if (ev_mid || ev_blow) go_err = 1'b1;
        end
        K_H: begin
          if (ev_key) begin
            if (locked) go_err = 1'b1;
            else begin
              st_d = K_TRY; sel_d = SEL_TRIM_PU; cnt_d = '0; try_load = 1'b1;
            end
          end else if (ev_mid) begin
            st_d = K_HM; cnt_d = C_ONE;
          end else if (ev_blow) go_err = 1'b1;
        end
        K_HM: begin
          if (ev_mid) cnt_d = cnt_inc;
          else if (ev_key) begin
            if (cnt_q == C_ONE) begin
              st_d = K_HMH; cnt_d = '0;
            end else if (cnt_q == C_OUT) begin
              st_d = K_TRY; sel_d = SEL_OUTCHK; cnt_d = '0; try_load = 1'b1;
            end else go_err = 1'b1;
          end else if (ev_blow) go_err = 1'b1;
        end
        K_HMH: begin
          if (ev_key) begin
            if (locked) go_err = 1'b1;
            else begin
              st_d = K_TRY; sel_d = SEL_TRIM_NU; cnt_d = '0; try_load = 1'b1;
            end
          end else if (ev_mid) begin
            st_d = K_HMHM; cnt_d = C_ONE;
          end else if (ev_blow) go_err = 1'b1;
        end
        K_HMHM: begin
          if (ev_mid) cnt_d = cnt_inc;
          else if (ev_key) begin
            if (cnt_q == C_MODE && !locked) begin
              st_d = K_FUSE; sel_d = SEL_F_SIGN; cnt_d = '0; fuse_load = 1'b1;
            end else go_err = 1'b1;
          end else if (ev_blow) go_err = 1'b1;
        end
        K_TRY: begin
          if (ev_mid) begin
            try_inc = 1'b1;
            cnt_d   = cnt_inc;
          end else if (ev_key) begin
            unique case (sel_q)
              SEL_TRIM_PU: begin
                if (cnt_q == C_DOWN) begin
                  sel_d = SEL_TRIM_PD; cnt_d = '0; try_load = 1'b1;
                end else if (cnt_q == C_MODE && !locked) begin
                  st_d = K_FUSE; sel_d = SEL_F_MAG; cnt_d = '0; fuse_load = 1'b1;
                end else go_err = 1'b1;
              end
              SEL_TRIM_NU: begin
                if (cnt_q == C_DOWN) begin
                  sel_d = SEL_TRIM_ND; cnt_d = '0; try_load = 1'b1;
                end else go_err = 1'b1;
              end
              SEL_OUTCHK: begin
                if (cnt_q == C_MODE && !locked) begin
                  st_d = K_FUSE; sel_d = SEL_F_OLCK; cnt_d = '0; fuse_load = 1'b1;
                end else go_err = 1'b1;
              end
              default: go_err = 1'b1;
            endcase
          end else if (ev_blow) go_err = 1'b1;
        end
        K_FUSE: begin
          if (ev_mid) begin
            if (addr_top) go_err = 1'b1;
            else fuse_shift = 1'b1;
          end else if (ev_key) go_err = 1'b1;
          else if (ev_blow) begin
            st_d  = K_BLOWN;
            stb_d = 1'b1;
          end
        end
        default: begin
        end
      endcase
      if (go_err) begin
        st_d  = K_ERR;
        sel_d = SEL_NONE;
        cnt_d = '0;
      end
    end
  end

  always_comb begin
    code_clr = pwr_cycle | go_err | fuse_load;
    fuse_clr = pwr_cycle | go_err;
    wrap_en  = (sel_q == SEL_TRIM_PU) || (sel_q == SEL_TRIM_NU) ||
               (sel_q == SEL_TRIM_PD) || (sel_q == SEL_TRIM_ND);
    err      = (st_q == K_ERR);
    blow_stb = stb_q;
    unique case (st_q)
      K_TRY:   mode = MODE_TRY;
      K_FUSE:  mode = MODE_READ;
      K_BLOWN: mode = MODE_BLOW;
      default: mode = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= K_IDLE;
      sel_q <= SEL_NONE;
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end
endmodule

// File: rtl/hk_try_code.sv
module hk_try_code
  import hk_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              inc,
  input  logic              wrap_en,
  input  sel_e              sel,
  input  logic              locked,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] mag_sel,
  output logic              trim_neg,
  output logic [1:0]        fall_sel,
  output logic              pol_sel,
  output logic              chk_lo,
  output logic              chk_hi
);
  localparam logic [CODE_W-1:0] C_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] C_ONE = CODE_W'(1);
  localparam logic [CODE_W-1:0] C_LO  = CODE_W'(8);
  localparam logic [CODE_W-1:0] C_HI  = CODE_W'(9);

  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    code_en = clr | load | inc;
    code_d  = code_q;
    if (clr)       code_d = '0;
    else if (load) code_d = C_ONE;
    else if (inc) begin
      if (wrap_en || code_q != C_MAX) code_d = code_q + C_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  logic is_out;

  always_comb begin
    code     = code_q;
    is_out   = (sel == SEL_OUTCHK);
    trim_neg = (sel == SEL_TRIM_NU) || (sel == SEL_TRIM_ND);
    unique case (sel)
      SEL_TRIM_PU, SEL_TRIM_NU: mag_sel = code_q;
      SEL_TRIM_PD, SEL_TRIM_ND: mag_sel = ~code_q;
      default:                  mag_sel = '0;
    endcase
    fall_sel = (is_out && !locked) ? code_q[1:0] : 2'b00;
    pol_sel  = is_out && !locked && code_q[2];
    chk_lo   = is_out && (code_q == C_LO);
    chk_hi   = is_out && (code_q == C_HI);
  end
endmodule

// File: rtl/hk_fuse_addr.sv
module hk_fuse_addr
  import hk_pkg::*;
#(
  parameter int MAG_BITS  = 8,
  parameter int SIGN_BITS = 1,
  parameter int OL_BITS   = 5,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              shift,
  input  sel_e              sel,
  output logic [ADDR_W-1:0] addr,
  output logic              at_top
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic [ADDR_W-1:0] top_mask [3];

  localparam int TOPS [3] = '{MAG_BITS - 1, SIGN_BITS - 1, OL_BITS - 1};

  for (genvar g = 0; g < 3; g++) begin : g_mask
    assign top_mask[g] = A_ONE << TOPS[g];
  end

  always_comb begin
    addr_en = clr | load | shift;
    addr_d  = addr_q;
    if (clr)        addr_d = '0;
    else if (load)  addr_d = A_ONE;
    else if (shift) addr_d = addr_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_comb begin
    addr = addr_q;
    unique case (sel)
      SEL_F_MAG:  at_top = |(addr_q & top_mask[0]);
      SEL_F_SIGN: at_top = |(addr_q & top_mask[1]);
      SEL_F_OLCK: at_top = |(addr_q & top_mask[2]);
      default:    at_top = 1'b0;
    endcase
  end
endmodule

// File: rtl/hk_key_decoder.sv
module hk_key_decoder
  import hk_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int ACT_MIN   = 4,
  parameter int BLOW_MIN  = 20,
  parameter int CODE_W    = 8,
  parameter int RUN_DOWN  = 4,
  parameter int RUN_MODE  = 11,
  parameter int RUN_OUT   = 3,
  parameter int MAG_BITS  = 8,
  parameter int SIGN_BITS = 1,
  parameter int OL_BITS   = 5,
  localparam int ADDR_W   = (MAG_BITS > OL_BITS) ?
                            ((MAG_BITS > SIGN_BITS) ? MAG_BITS : SIGN_BITS) :
                            ((OL_BITS > SIGN_BITS) ? OL_BITS : SIGN_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_cycle,
  input  logic              lock_fuse,
  input  logic              pulse_valid,
  input  logic              pulse_kind,
  input  logic [LEN_W-1:0]  pulse_len,
  output logic [3:0]        sel,
  output logic [1:0]        mode,
  output logic              err,
  output logic              blow_stb,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] mag_sel,
  output logic              trim_neg,
  output logic [1:0]        fall_sel,
  output logic              pol_sel,
  output logic              chk_lo,
  output logic              chk_hi,
  output logic [ADDR_W-1:0] fuse_addr
);
  logic  ev_mid, ev_key, ev_blow;
  sel_e  sel_q;
  mode_e mode_w;
  logic  addr_top;
  logic  try_load, try_inc, wrap_en, code_clr;
  logic  fuse_load, fuse_shift, fuse_clr;

  hk_pulse_class #(
    .LEN_W(LEN_W), .ACT_MIN(ACT_MIN), .BLOW_MIN(BLOW_MIN)
  ) u_class (
    .valid(pulse_valid), .kind(pulse_kind), .len(pulse_len),
    .ev_mid(ev_mid), .ev_key(ev_key), .ev_blow(ev_blow)
  );

  hk_key_fsm #(
    .RUN_DOWN(RUN_DOWN), .RUN_MODE(RUN_MODE), .RUN_OUT(RUN_OUT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle),
    .ev_mid(ev_mid), .ev_key(ev_key), .ev_blow(ev_blow),
    .locked(lock_fuse), .addr_top(addr_top),
    .sel_q(sel_q), .mode(mode_w), .err(err), .blow_stb(blow_stb),
    .try_load(try_load), .try_inc(try_inc), .wrap_en(wrap_en),
    .code_clr(code_clr), .fuse_load(fuse_load), .fuse_shift(fuse_shift),
    .fuse_clr(fuse_clr)
  );

  hk_try_code #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .clr(code_clr), .load(try_load),
    .inc(try_inc), .wrap_en(wrap_en), .sel(sel_q), .locked(lock_fuse),
    .code(code), .mag_sel(mag_sel), .trim_neg(trim_neg),
    .fall_sel(fall_sel), .pol_sel(pol_sel), .chk_lo(chk_lo), .chk_hi(chk_hi)
  );

  hk_fuse_addr #(
    .MAG_BITS(MAG_BITS), .SIGN_BITS(SIGN_BITS), .OL_BITS(OL_BITS),
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(fuse_clr), .load(fuse_load),
    .shift(fuse_shift), .sel(sel_q), .addr(fuse_addr), .at_top(addr_top)
  );

  assign sel  = sel_q;
  assign mode = mode_w;
endmodule

// File: rtl/hk_key_chk.sv
module hk_key_chk #(
  parameter int LEN_W   = 8,
  parameter int ACT_MIN = 4,
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_cycle,
  input logic              lock_fuse,
  input logic              pulse_valid,
  input logic              pulse_kind,
  input logic [LEN_W-1:0]  pulse_len,
  input logic [3:0]        sel,
  input logic [1:0]        mode,
  input logic              err,
  input logic              blow_stb,
  input logic [CODE_W-1:0] code,
  input logic [ADDR_W-1:0] fuse_addr
);
  logic mid_ok;
  logic trim_sel;
  assign mid_ok   = pulse_valid && !pulse_kind && (pulse_len >= LEN_W'(ACT_MIN));
  assign trim_sel = (sel >= 4'd1) && (sel <= 4'd4);

  AST_BLOW_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    blow_stb |-> (mode == 2'd3 && $past(mode) == 2'd2)); // R9
  AST_BLOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    blow_stb |=> !blow_stb); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !pwr_cycle) |=> err); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (sel == 4'd0 && mode == 2'd0)); // R10
  AST_FUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> ($countones(fuse_addr) == 1)); // R3
  AST_PWR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle |=> (mode == 2'd0 && !err && sel == 4'd0 && code == '0)); // R11
  AST_TRIM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && trim_sel && code == '1 && mid_ok && !pwr_cycle) |=> code == '0); // R4
  AST_LOCK_OUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_fuse) && mode == 2'd1 && $past(mode) != 2'd1) |-> sel == 4'd5); // R7
endmodule

bind hk_key_decoder hk_key_chk #(
  .LEN_W(LEN_W), .ACT_MIN(ACT_MIN), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .lock_fuse(lock_fuse),
  .pulse_valid(pulse_valid), .pulse_kind(pulse_kind), .pulse_len(pulse_len),
  .sel(sel), .mode(mode), .err(err), .blow_stb(blow_stb), .code(code),
  .fuse_addr(fuse_addr)
);

// File: tb/tb_hk_key_decoder.sv
module tb_hk_key_decoder;
  logic       clk = 1'b0;
  logic       rst_n, pwr_cycle, lock_fuse, pulse_valid, pulse_kind;
  logic [7:0] pulse_len;
  logic [3:0] sel;
  logic [1:0] mode;
  logic       err, blow_stb, trim_neg, pol_sel, chk_lo, chk_hi;
  logic [7:0] code, mag_sel, fuse_addr;
  logic [1:0] fall_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  hk_key_decoder dut (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .lock_fuse(lock_fuse),
    .pulse_valid(pulse_valid), .pulse_kind(pulse_kind), .pulse_len(pulse_len),
    .sel(sel), .mode(mode), .err(err), .blow_stb(blow_stb), .code(code),
    .mag_sel(mag_sel), .trim_neg(trim_neg), .fall_sel(fall_sel),
    .pol_sel(pol_sel), .chk_lo(chk_lo), .chk_hi(chk_hi), .fuse_addr(fuse_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic pulse(input logic k, input int len);
    @(negedge clk);
    pulse_valid = 1'b1; pulse_kind = k; pulse_len = 8'(len);
    @(negedge clk);
    pulse_valid = 1'b0;
  endtask

  task automatic hp();  pulse(1'b1, 8);  endtask
  task automatic mp();  pulse(1'b0, 8);  endtask
  task automatic blow(); pulse(1'b1, 30); endtask
  task automatic mps(input int n);
    for (int i = 0; i < n; i++) mp();
  endtask

  task automatic pwr();
    @(negedge clk); pwr_cycle = 1'b1;
    @(negedge clk); pwr_cycle = 1'b0;
  endtask

  task automatic enter_trim(input int s);
    pwr();
    case (s)
      1: begin hp(); hp(); end
      2: begin hp(); mp(); hp(); hp(); end
      3: begin hp(); hp(); mps(4); hp(); end
      default: begin hp(); mp(); hp(); hp(); mps(4); hp(); end
    endcase
  endtask

  task automatic enter_fuse(input int s);
    pwr();
    case (s)
      6: begin hp(); hp(); mps(11); hp(); end
      7: begin hp(); mp(); hp(); mps(11); hp(); end
      default: begin hp(); mps(3); hp(); mps(11); hp(); end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; pwr_cycle = 1'b0; lock_fuse = 1'b0;
    pulse_valid = 1'b0; pulse_kind = 1'b0; pulse_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 sel", sel, 0);   chk("R12 mode", mode, 0);
    chk("R12 code", code, 0); chk("R12 addr", fuse_addr, 0);
    chk("R12 err", err, 0);   chk("R12 stb", blow_stb, 0);

    // R1, R2: every trial key
    for (int s = 1; s <= 4; s++) begin
      enter_trim(s);
      chk("R1/R2 sel", sel, s); chk("R1/R2 mode", mode, 1);
      chk("R1/R2 code", code, 1); chk("R1/R2 err", err, 0);
    end
    pwr(); hp(); mps(3); hp();
    chk("R1 out sel", sel, 5); chk("R1 out mode", mode, 1); chk("R1 out code", code, 1);

    // R4, R5: sweep each trim register through the wrap
    for (int s = 1; s <= 4; s++) begin
      enter_trim(s);
      for (int n = 1; n <= 300; n++) begin
        int e;
        mp();
        e = (1 + n) % 256;
        chk("R4 trim code", code, e);
        chk("R5 mag_sel", mag_sel, (s >= 3) ? 255 - e : e);
        chk("R5 trim_neg", trim_neg, (s == 2 || s == 4) ? 1 : 0);
      end
    end

    // R4, R6: output register fields and saturation
    pwr(); hp(); mps(3); hp();
    for (int n = 0; n <= 260; n++) begin
      int e;
      if (n > 0) mp();
      e = (1 + n > 255) ? 255 : 1 + n;
      chk("R4 out sat", code, e);
      chk("R6 fall", fall_sel, e % 4);
      chk("R6 pol", pol_sel, (e / 4) % 2);
      chk("R6 chk_lo", chk_lo, (e == 8) ? 1 : 0);
      chk("R6 chk_hi", chk_hi, (e == 9) ? 1 : 0);
    end

    // R3: fuse access, address walk and overrun
    for (int s = 6; s <= 8; s++) begin
      int w;
      w = (s == 6) ? 8 : (s == 7) ? 1 : 5;
      enter_fuse(s);
      chk("R3 sel", sel, s); chk("R3 mode", mode, 2); chk("R3 addr0", fuse_addr, 1);
      for (int b = 1; b < w; b++) begin
        mp();
        chk("R3 addr step", fuse_addr, 1 << b);
      end
      mp();
      chk("R3 overrun err", err, 1);
      chk("R3 overrun addr", fuse_addr, 0);
    end

    // R9: blow at each bit
    for (int b = 0; b < 8; b++) begin
      enter_fuse(6);
      mps(b);
      blow();
      chk("R9 stb", blow_stb, 1); chk("R9 mode", mode, 3);
      chk("R9 addr", fuse_addr, 1 << b);
      @(negedge clk);
      chk("R9 stb width", blow_stb, 0);
      mp(); hp();
      chk("R9 ignore addr", fuse_addr, 1 << b); chk("R9 ignore mode", mode, 3);
      chk("R9 ignore err", err, 0);
    end
    pwr(); hp(); hp(); blow();
    chk("R9 long H in try", err, 1); chk("R9 no stb", blow_stb, 0);
    enter_fuse(8); hp();
    chk("R9 short H in read", err, 1);

    // R8: short pulses
    pwr(); pulse(1'b1, 3); pulse(1'b0, 3);
    chk("R8 idle err", err, 0); chk("R8 idle sel", sel, 0);
    hp(); hp(); pulse(1'b0, 3);
    chk("R8 try code", code, 1); chk("R8 try sel", sel, 1);
    pulse(1'b1, 3);
    chk("R8 try err", err, 0); chk("R8 try mode", mode, 1);

    // R7: locked
    lock_fuse = 1'b1;
    pwr(); hp(); hp();
    chk("R7 lock pu", err, 1);
    pwr(); hp(); mp(); hp(); hp();
    chk("R7 lock nu", err, 1);
    pwr(); hp(); mp(); hp(); mps(11); hp();
    chk("R7 lock sign", err, 1);
    pwr(); hp(); mps(3); hp();
    chk("R7 lock out sel", sel, 5);
    mps(6);
    chk("R7 lock code", code, 7); chk("R7 lock fall", fall_sel, 0);
    chk("R7 lock pol", pol_sel, 0);
    mp();
    chk("R7 lock chk_lo", chk_lo, 1);
    mps(4); hp();
    chk("R7 lock olck", err, 1);
    lock_fuse = 1'b0;

    // R10: unmatched sequences
    pwr(); mp();
    chk("R10 lead mid", err, 1); chk("R10 sel", sel, 0); chk("R10 mode", mode, 0);
    hp(); hp();
    chk("R10 sticky", err, 1);
    pwr(); hp(); mps(2); hp();
    chk("R10 two mids", err, 1);
    pwr(); hp(); hp(); mps(5); hp();
    chk("R10 five mids", err, 1);

    // R11: power cycle and pulse in one cycle
    pwr(); hp(); hp(); mps(3);
    @(negedge clk);
    pwr_cycle = 1'b1; pulse_valid = 1'b1; pulse_kind = 1'b1; pulse_len = 8'd8;
    @(negedge clk);
    pwr_cycle = 1'b0; pulse_valid = 1'b0;
    chk("R11 mode", mode, 0); chk("R11 sel", sel, 0); chk("R11 code", code, 0);
    hp(); hp();
    chk("R11 pulse dropped sel", sel, 1); chk("R11 pulse dropped err", err, 0);

    summary();
  end
endmodule